// File: doc/BRIEF.md
# Keyed-Reload Watchdog Timer

This block is a memory-mapped watchdog with three 32-bit registers on a simple single-cycle register bus. Software writes a mode register to start it and to choose an interval from a 4-bit code. The codes map onto a non-linear set of periods, from half a second up to sixteen seconds. Once the watchdog is running, the countdown restarts only when a control write carries a fixed key word. Any other value written to the control register leaves the countdown alone.

When the countdown expires and the config register selects the system-reset action, the block raises a reset output for a fixed number of clock cycles and then clears its own enable bit. The parameter `HALF_SEC_CYCLES` sets how many clock cycles make up half a second. The parameter `PULSE_CYCLES` sets the length of the reset pulse.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the watchdog is disabled and `rst_out` is low. The config register and the mode register both read as zero.
- R2: A write to control (offset 0x10) restarts the countdown to the full current period only when data bits [12:0] equal 0x14AF. That value is bit 0 set with 0xA57 in bits [12:1].
- R3: A control write with any other value in bits [12:0] has no effect on the countdown.
- R4: Mode bits [7:4] select the period in half-second units. The codes map as follows: 0→1, 1→2, 2→4, 3→6, 4→8, 5→10, 6→12, 7→16, 8→20, 9→24, 0xA→28, and 0xB through 0xF→32. Expiry comes exactly `period × HALF_SEC_CYCLES` cycles after the countdown is loaded.
- R5: A mode write (offset 0x18) with bit 0 set loads the countdown from the new code if the watchdog was off or if the code changes. Rewriting the same code with bit 0 set while the watchdog runs leaves the countdown running.
- R6: Config bits [1:0] (offset 0x14) select the expiry action, and only the value 01 selects reset. With any other value, expiry reloads the countdown and raises no pulse.
- R7: With reset selected, expiry drives `rst_out` high for exactly `PULSE_CYCLES` cycles. After the pulse, mode bit 0 reads 0 and the interval code is kept.
- R8: Writing zero to mode stops the countdown, so no expiry follows.
- R9: Reads of config return bits [1:0] and reads of mode return the code in [7:4] and enable in bit 0. All other bits read zero, and control reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Bus access strobe |
| we | input | 1 | Write when high, read when low |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| rst_out | output | 1 | System reset pulse |

## Verification
The hardest behaviour to reach is a control or mode write that lands a few cycles before expiry. In that case the only visible difference between a reload and an ignored write is the cycle on which `rst_out` rises. The bench uses a tiny half-second length, starts the watchdog, and issues the write at a fixed cycle offset. It then counts cycles up to the pulse and compares the count with the arithmetic expectation for a reload, a non-reload or a code-change reload. Every interval code is also swept and its period measured the same way.

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int HALF_SEC_CYCLES = 12_000_000,
  parameter int PULSE_CYCLES    = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        we,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        rst_out
);
  localparam int CNT_W = $clog2(32 * HALF_SEC_CYCLES + 1);
  localparam int PW    = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
  localparam logic [7:0] A_CTRL = 8'h10;
  localparam logic [7:0] A_CFG  = 8'h14;
  localparam logic [7:0] A_MODE = 8'h18;
  localparam logic [12:0] KEY   = 13'h14AF;

  logic             en, pulsing;
  logic [3:0]       code;
  logic [1:0]       cfg;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [PW-1:0]    pcnt;
  logic             fire;

  function automatic logic [CNT_W-1:0] period(input logic [3:0] c);
    logic [5:0] h;
    case (c)
      4'h0: h = 6'd1;
      4'h1: h = 6'd2;
      4'h2: h = 6'd4;
      4'h3: h = 6'd6;
      4'h4: h = 6'd8;
      4'h5: h = 6'd10;
      4'h6: h = 6'd12;
      4'h7: h = 6'd16;
      4'h8: h = 6'd20;
      4'h9: h = 6'd24;
      4'hA: h = 6'd28;
      default: h = 6'd32;
    endcase
    return CNT_W'(h) * CNT_W'(HALF_SEC_CYCLES);
  endfunction

  wire wr_ctrl   = req & we & (addr == A_CTRL);
  wire wr_cfg    = req & we & (addr == A_CFG);
  wire wr_mode   = req & we & (addr == A_MODE);
  wire key_ok    = wdata[12:0] == KEY;
  wire reload    = wr_ctrl & key_ok & en;
  wire load_mode = wr_mode & wdata[0] & (~en | (wdata[7:4] != code));
  wire stop      = wr_mode & ~wdata[0];

  always_comb begin
    cnt_n = cnt;
    fire  = 1'b0;
    if (load_mode)
      cnt_n = period(wdata[7:4]) - 1'b1;
    else if (en && !stop) begin
      if (reload)
        cnt_n = period(code) - 1'b1;
      else if (cnt == '0) begin
        fire  = 1'b1;
        cnt_n = period(code) - 1'b1;
      end else
        cnt_n = cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= 1'b0;
      code    <= '0;
      cfg     <= '0;
      cnt     <= '0;
      pcnt    <= '0;
      pulsing <= 1'b0;
    end else begin
      if (wr_cfg) cfg <= wdata[1:0];
      if (pulsing) begin
        pcnt <= pcnt - 1'b1;
        if (pcnt == '0) begin
          pulsing <= 1'b0;
          en      <= 1'b0;
        end
      end else begin
        cnt <= cnt_n;
        if (wr_mode) begin
          code <= wdata[7:4];
          en   <= wdata[0];
        end
        if (fire && cfg == 2'b01) begin
          pulsing <= 1'b1;
          pcnt    <= PW'(PULSE_CYCLES - 1);
        end
      end
    end
  end

  assign rst_out = pulsing;
  assign rdata = (addr == A_CFG)  ? {30'b0, cfg} :
                 (addr == A_MODE) ? {24'b0, code, 3'b0, en} : 32'b0;

  AST_BAD_KEY_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl && !key_ok && en && !pulsing && cnt != '0 |=> cnt == $past(cnt) - 1'b1); // R3
  AST_PULSE_NEEDS_RESET_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out) |-> $past(en) && $past(cfg) == 2'b01); // R6
  AST_EN_CLEARED_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out) |-> !en && rdata[0] == 1'b0 || addr != A_MODE); // R7
  AST_STOPPED_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !pulsing |=> !rst_out); // R8
  AST_KEY_RELOAD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl && key_ok && en && !pulsing |=> cnt == period(code) - 1'b1); // R2
endmodule

// File: tb/keyed_wdt_tb.sv
module keyed_wdt_tb;
  localparam int HALF = 3;
  localparam int PW   = 16;
  logic clk = 0, rst_n = 0, req = 0, we = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic rst_out;
  int checks = 0, fails = 0, cyc = 0;

  keyed_wdt #(.HALF_SEC_CYCLES(HALF), .PULSE_CYCLES(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rst_out(rst_out));

  always #2.5 clk = ~clk;

  function automatic int halves(input int c);
    case (c)
      0: return 1; 1: return 2; 2: return 4; 3: return 6; 4: return 8;
      5: return 10; 6: return 12; 7: return 16; 8: return 20; 9: return 24;
      10: return 28; default: return 32;
    endcase
  endfunction

  task automatic chk(input string r, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic wait_pulse(inout int n);
    while (!rst_out && n < 400) begin @(negedge clk); n++; end
  endtask

  task automatic pulse_width(output int w);
    w = 0;
    while (rst_out && w < 100) begin @(negedge clk); w++; end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int n, w;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 rst_out", rst_out, 0);
    rd(8'h14, d); chk("R1 cfg", d, 0);
    rd(8'h18, d); chk("R1 mode", d, 0);

    wr(8'h14, 32'hFFFF_FFFD);
    rd(8'h14, d); chk("R9 cfg read", d, 1);
    rd(8'h10, d); chk("R9 ctrl read", d, 0);

    for (int c = 0; c < 16; c++) begin
      wr(8'h18, (c << 4) | 32'h1);
      n = 0; wait_pulse(n);
      chk($sformatf("R4 code %0d period", c), n, halves(c) * HALF);
      pulse_width(w);
      chk("R7 pulse width", w, PW);
      rd(8'h18, d);
      chk("R7 enable cleared, code kept", d, (c << 4));
    end

    wr(8'h18, 32'h11); repeat (3) @(negedge clk);
    wr(8'h10, 32'h0000_14AE); n = 5; wait_pulse(n);
    chk("R3 bad key ignored", n, 6); pulse_width(w);

    wr(8'h18, 32'h11); repeat (3) @(negedge clk);
    wr(8'h10, 32'h0000_0A57); n = 5; wait_pulse(n);
    chk("R3 unshifted key ignored", n, 6); pulse_width(w);

    wr(8'h18, 32'h11); repeat (3) @(negedge clk);
    wr(8'h10, 32'hFFFF_F4AF); n = 5; wait_pulse(n);
    chk("R2 key reload", n, 11); pulse_width(w);

    wr(8'h18, 32'h11); repeat (3) @(negedge clk);
    wr(8'h18, 32'h11); n = 5; wait_pulse(n);
    chk("R5 same code no restart", n, 6); pulse_width(w);

    wr(8'h18, 32'h11); repeat (3) @(negedge clk);
    wr(8'h18, 32'h21); n = 5; wait_pulse(n);
    chk("R5 code change reloads", n, 17); pulse_width(w);

    wr(8'h18, 32'h11); repeat (3) @(negedge clk);
    wr(8'h18, 32'h0); n = 5; wait_pulse(n);
    chk("R8 stopped no pulse", n, 400);
    rd(8'h18, d); chk("R8 mode reads zero", d, 0);

    wr(8'h14, 32'h2);
    wr(8'h18, 32'h1); n = 0; wait_pulse(n);
    chk("R6 cfg 10 no pulse", n, 400);
    rd(8'h18, d); chk("R6 still enabled", d, 1);
    wr(8'h14, 32'h0); n = 0; wait_pulse(n);
    chk("R6 cfg 00 no pulse", n, 400);
    wr(8'h14, 32'h1); n = 0; wait_pulse(n);
    chk("R6 cfg 01 pulses within period", (n <= HALF) ? 1 : 0, 1);
    pulse_width(w); chk("R7 width after cfg change", w, PW);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule